// File: doc/BRIEF.md
# Write-Completion Probe Sequencer

This block sits between a serial-bus command controller and a bit-level bus engine. After the controller has ended a write transfer with STOP, the memory on the bus runs an internal programming cycle and ignores requests until it is done. The sequencer removes the need for a fixed worst-case wait. It issues a START, sends the device-select byte, and reads back the acknowledge bit. It repeats this pair until the memory acknowledges. Typical programming is faster than the worst case, so the handoff usually comes well before the maximum delay.

When a probe is acknowledged, the select byte that was just sent already counts as the opening byte of the next instruction. The sequencer pulses `ready` and leaves the bus claimed: it issues no STOP, so the controller continues with the address or data bytes. The read/write bit of the probe comes from the command that is queued next. A probe limit stops the loop. Once the limit is reached, the sequencer releases the bus with STOP and pulses `timeout`.

The bus engine accepts one request at a time. Each request is held until the engine answers with a one-cycle `phy_done`, and `phy_ack` is valid together with `phy_done` for a byte request.

Top module: `poll_sequencer`

## Requirements
- R1: While reset is applied, and after it is released, `busy`, `phy_req`, `ready` and `timeout` are low, `phy_op` is 0 (none) and `probe_count` is 0.
- R2: A `go` pulse while idle raises `busy` and requests a START (`phy_op` = 1) from the next cycle on.
- R3: When a START completes, the next cycle requests a byte (`phy_op` = 2). `phy_byte` equals {`dev_addr`, `next_rw`} as captured at `go`, with the read/write flag in bit 0 (1 = read). Later changes on `dev_addr` or `next_rw` do not alter it.
- R4: A probe byte answered with `phy_ack` = 0 (not acknowledged), when fewer than MAX_TRIES probes have completed, is followed in the next cycle by a new START request.
- R5: A probe byte answered with `phy_ack` = 1 causes, in the next cycle, a one-cycle `ready` pulse, with `busy` and `phy_req` low. No STOP (`phy_op` = 3) is requested in that sequence.
- R6: When the MAX_TRIES-th probe is not acknowledged, a STOP is requested in the next cycle. After that STOP completes, `timeout` pulses for one cycle and `busy` drops in the same cycle.
- R7: `probe_count` counts the probe bytes completed since the last accepted `go`, never exceeds MAX_TRIES, and holds its value after the sequence ends.
- R8: A `go` pulse while `busy` is high has no effect on the sequence or on `phy_byte`.
- R9: A request holds `phy_req` and `phy_op` steady until its `phy_done` cycle.
- R10: `ready` and `timeout` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| go | input | 1 | Start polling, pulse |
| dev_addr | input | ADDR_W | Device address of the memory |
| next_rw | input | 1 | Direction of the queued command, 1 = read |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | One-cycle pulse: memory acknowledged, bus still claimed |
| timeout | output | 1 | One-cycle pulse: probe limit reached, bus released |
| probe_count | output | $clog2(MAX_TRIES+1) | Probes completed in the current or last sequence |
| phy_req | output | 1 | Request valid toward the bus engine |
| phy_op | output | 2 | 0 none, 1 START, 2 byte, 3 STOP |
| phy_byte | output | ADDR_W+1 | Byte to send with a byte request |
| phy_done | input | 1 | Bus engine finished the current request, one cycle |
| phy_ack | input | 1 | Acknowledge bit of the byte just sent, 1 = acknowledged |

## Verification
The bench builds the block with MAX_TRIES = 4, so a timeout takes only a handful of probes. It also brings within reach the boundary where the last allowed probe is acknowledged rather than refused. The responder uses bus-engine latencies of zero to three cycles, which exercises back-to-back and held requests. A reference model predicts every output on every clock while the bench changes the address and pulses `go` in the middle of a sequence.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_START = 2'd1,
    OP_BYTE  = 2'd2,
    OP_STOP  = 2'd3
  } phy_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_PROBE,
    ST_STOP
  } poll_st_e;
endpackage

// File: rtl/poll_rst_sync.sv
module poll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/poll_select_byte.sv
module poll_select_byte #(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              rw,
  output logic [BYTE_W-1:0] sel_byte
);
  logic [BYTE_W-1:0] sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (load) sel_d = {dev_addr, rw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= '0;
    else if (load) sel_q <= sel_d;
  end

  assign sel_byte = sel_q;

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sel_byte == $past({dev_addr, rw}));
endmodule

// File: rtl/poll_try_counter.sv
module poll_try_counter #(
  parameter int MAX_TRIES = 200,
  localparam int TRY_W = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [TRY_W-1:0] count,
  output logic             last
);
  logic [TRY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | inc;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + TRY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign last  = (cnt_q == TRY_W'(MAX_TRIES - 1));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TRY_W'(MAX_TRIES));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
  import poll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       phy_done,
  input  logic       phy_ack,
  input  logic       cnt_last,
  output logic       busy,
  output logic       phy_req,
  output logic [1:0] phy_op,
  output logic       cnt_clr,
  output logic       cnt_inc,
  output logic       sel_load,
  output logic       ready,
  output logic       timeout
);
  poll_st_e st_q, st_d;
  logic     ready_q, ready_d;
  logic     to_q, to_d;

  always_comb begin
    st_d     = st_q;
    ready_d  = 1'b0;
    to_d     = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    sel_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          st_d     = ST_START;
          cnt_clr  = 1'b1;
          sel_load = 1'b1;
        end
      end
      ST_START: begin
        if (phy_done) st_d = ST_PROBE;
      end
      ST_PROBE: begin
        if (phy_done) begin
          cnt_inc = 1'b1;
          if (phy_ack) begin
            st_d    = ST_IDLE;
            ready_d = 1'b1;
          end else if (cnt_last) begin
            st_d = ST_STOP;
          end else begin
            st_d = ST_START;
          end
        end
      end
      ST_STOP: begin
        if (phy_done) begin
          st_d = ST_IDLE;
          to_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ready_q <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      ready_q <= ready_d;
      to_q    <= to_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: phy_op = OP_START;
      ST_PROBE: phy_op = OP_BYTE;
      ST_STOP:  phy_op = OP_STOP;
      default:  phy_op = OP_NONE;
    endcase
  end

  assign busy    = (st_q != ST_IDLE);
  assign phy_req = busy;
  assign ready   = ready_q;
  assign timeout = to_q;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_done) |=> (phy_req && $stable(phy_op)));
  p_start_then_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_op == OP_START && phy_done) |=> phy_op == OP_BYTE);
  p_nack_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_op == OP_BYTE && phy_done && !phy_ack && !cnt_last) |=> phy_op == OP_START);
  p_ack_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_op == OP_BYTE && phy_done && phy_ack) |=> (ready && !phy_req));
  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  p_stop_then_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_op == OP_STOP && phy_done) |=> (timeout && !busy));
  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && timeout));
endmodule

// File: rtl/poll_sequencer.sv
module poll_sequencer
  import poll_pkg::*;
#(
  parameter int MAX_TRIES = 200,
  parameter int ADDR_W    = 7,
  localparam int TRY_W    = $clog2(MAX_TRIES + 1),
  localparam int BYTE_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              next_rw,
  output logic              busy,
  output logic              ready,
  output logic              timeout,
  output logic [TRY_W-1:0]  probe_count,
  output logic              phy_req,
  output logic [1:0]        phy_op,
  output logic [BYTE_W-1:0] phy_byte,
  input  logic              phy_done,
  input  logic              phy_ack
);
  logic srst_n;
  logic cnt_clr, cnt_inc, cnt_last, sel_load;

  poll_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (srst_n)
  );

  poll_fsm u_fsm (
    .clk      (clk),
    .rst_n    (srst_n),
    .go       (go),
    .phy_done (phy_done),
    .phy_ack  (phy_ack),
    .cnt_last (cnt_last),
    .busy     (busy),
    .phy_req  (phy_req),
    .phy_op   (phy_op),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .sel_load (sel_load),
    .ready    (ready),
    .timeout  (timeout)
  );

  poll_try_counter #(.MAX_TRIES(MAX_TRIES)) u_cnt (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (probe_count),
    .last  (cnt_last)
  );

  poll_select_byte #(.ADDR_W(ADDR_W)) u_sel (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (sel_load),
    .dev_addr (dev_addr),
    .rw       (next_rw),
    .sel_byte (phy_byte)
  );

  p_go_ignored_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && go) |=> $stable(phy_byte));
  p_go_starts_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy && go) |=> (busy && phy_op == OP_START));
  p_stop_at_limit_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (phy_op == OP_STOP) |-> (probe_count == TRY_W'(MAX_TRIES)));
endmodule

// File: tb/test_poll_sequencer.sv
module test_poll_sequencer;
  localparam int MAXT  = 4;
  localparam int AW    = 7;
  localparam int TW    = $clog2(MAXT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [AW-1:0] dev_addr = '0;
  logic next_rw = 1'b0;
  logic busy, ready, timeout, phy_req;
  logic [TW-1:0] probe_count;
  logic [1:0] phy_op;
  logic [AW:0] phy_byte;
  logic phy_done = 1'b0;
  logic phy_ack = 1'b0;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  // responder settings (written by stimulus only)
  int nack_target = 0;
  int lat = 0;
  // responder state (written by responder only)
  int nacks_seen = 0;
  int waitc = 0;

  // reference model state
  int m_ph = 0;          // 0 idle, 1 start, 2 byte, 3 stop
  int m_cnt = 0;
  logic [AW:0] m_sel = '0;
  bit m_ready = 0, m_to = 0;

  always #2 clk = ~clk;

  poll_sequencer #(.MAX_TRIES(MAXT), .ADDR_W(AW)) i_poll_sequencer (
    .clk(clk), .rst_n(rst_n), .go(go), .dev_addr(dev_addr), .next_rw(next_rw),
    .busy(busy), .ready(ready), .timeout(timeout), .probe_count(probe_count),
    .phy_req(phy_req), .phy_op(phy_op), .phy_byte(phy_byte),
    .phy_done(phy_done), .phy_ack(phy_ack)
  );

  // reference model: advances on each rising edge
  always @(posedge clk) begin
    m_ready = 0;
    m_to = 0;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_sel = '0;
    end else begin
      case (m_ph)
        0: if (go) begin m_ph = 1; m_cnt = 0; m_sel = {dev_addr, next_rw}; end
        1: if (phy_done) m_ph = 2;
        2: if (phy_done) begin
             m_cnt++;
             if (phy_ack) begin m_ph = 0; m_ready = 1; end
             else if (m_cnt == MAXT) m_ph = 3;
             else m_ph = 1;
           end
        default: if (phy_done) begin m_ph = 0; m_to = 1; end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare on falling edge, then drive the bus-engine response
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      vectors++;
      chk("R2 busy", busy, m_ph != 0);
      chk("R9 phy_req", phy_req, m_ph != 0);
      chk("R4 phy_op", phy_op, m_ph);
      chk("R5 ready", ready, m_ready);
      chk("R6 timeout", timeout, m_to);
      chk("R7 probe_count", probe_count, m_cnt);
      chk("R10 ready with timeout", ready & timeout, 0);
      if (m_ph == 2) chk("R3 phy_byte", phy_byte, m_sel);
    end
    if (phy_done) begin
      phy_done <= 1'b0;
      phy_ack  <= 1'b0;
      waitc = 0;
    end else if (phy_req) begin
      if (waitc >= lat) begin
        phy_done <= 1'b1;
        if (phy_op == 2'd2) begin
          phy_ack <= (nacks_seen >= nack_target);
          nacks_seen++;
        end else phy_ack <= 1'b0;
        waitc = 0;
      end else waitc++;
    end else begin
      nacks_seen = 0;
      waitc = 0;
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic run(input logic [AW-1:0] a, input logic rw, input int nacks,
                     input int l, input bit poke);
    @(negedge clk);
    nack_target = nacks;
    lat = l;
    dev_addr = a;
    next_rw = rw;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    dev_addr = ~a;            // R3: later change must not show
    next_rw = ~rw;
    if (poke) begin           // R8: go while busy is ignored
      @(negedge clk);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
    end
    while (m_ph != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    vectors++;
    chk("R1 busy in reset", busy, 0);
    chk("R1 phy_op in reset", phy_op, 0);
    chk("R1 probe_count in reset", probe_count, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run(7'h50, 1'b1, 0, 0, 0);   // R5 first probe acknowledged, read
    chk("R5 probes on first ack", probe_count, 1);
    run(7'h51, 1'b0, 2, 1, 0);   // R4 two refusals then ack
    chk("R4 probes after two retries", probe_count, 3);
    run(7'h2a, 1'b1, 10, 0, 0);  // R6 timeout
    chk("R6 probes at limit", probe_count, MAXT);
    run(7'h13, 1'b0, MAXT - 1, 2, 1); // R5 last allowed probe acked, R8 go mid-run
    chk("R8 sequence unaffected by extra go", probe_count, MAXT);
    run(7'h7f, 1'b1, 10, 3, 1);  // R6 timeout with slow engine, R8
    run(7'h00, 1'b0, 1, 0, 0);   // R4 single retry
    chk("R7 count holds when idle", probe_count, 2);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule